// File: doc/BRIEF.md
# Debounced External Interrupt Controller

This block takes up to eight external level inputs and turns each into a clean, one-shot interrupt event. Every input is first synchronised into the clock domain. It is then qualified by a per-channel debounce counter that counts millisecond ticks while the input sits at its selected trigger level. A shared prescaler divides the input clock down to the millisecond tick. The prescaler holds itself at zero whenever no channel is counting, so the counting logic is quiet while every input is idle or already reported.

Software reaches the block through a simple register port with a write strobe, an address and write data, and with read data decoded combinationally from the address. Each channel has a control word that holds an enable, a trigger-level select and a 12-bit debounce value. A global mask word is followed by a write-1-to-clear status word. One active-high level interrupt output is the OR of the status bits that are both enabled and unmasked. After an event the channel stays silent until its input leaves the trigger level, so an input that is held does not fire again.

Top module: `ext_irq_debounce`

## Requirements
- R1: After reset every control word, the mask word and the status word read as zero, and `irq_out` is low.
- R2: Address i (0 to NCH-1) is channel i's control word: bit 0 enable, bit 1 trigger level (1 = high is the event, 0 = low is the event), bits 13:2 debounce value D. Address NCH is the mask word (bit i = 1 lets channel i through). Address NCH+1 is the status word. Writes to control and mask read back unchanged.
- R3: An enabled channel whose synchronised input stays at its trigger level across D+2 consecutive tick boundaries sets its status bit. When it is the only channel counting, starting from idle, the bit sets about (D+2)*DIV cycles after the input change.
- R4: An input held at the trigger level for less than one tick period never sets status. A hold that falls short of the R3 duration sets nothing either.
- R5: When the input leaves the trigger level, the channel's count restarts from zero, so separate short holds do not add up.
- R6: After an event, a channel raises no further event while its input stays at the trigger level, even once the status bit is cleared. A new event needs the input to leave the level and then qualify again.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle as a clear wins.
- R8: `irq_out` is high exactly when some status bit is set whose channel enable bit and mask bit are both 1.
- R9: The prescaler counter is held at zero while no channel is counting, and ticks are produced only while some channel is counting.
- R10: With the trigger level set to 0, a stable low input qualifies and a high input does not.
- R11: A channel whose enable bit is 0 never sets its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | NCH | Raw external inputs, one per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr |
| irq_out | output | 1 | Combined active-high level interrupt |

## Verification
A table of pulses is applied to different channels: high- and low-level triggers, debounce values from 0 to 4, and hold times just below and comfortably above the qualifying length. This separates correct tick counting from off-by-one counting and from polarity mistakes. Directed sequences then hold an input past an event and across a status clear, which tells single-trigger behaviour apart from re-arming on clear. A hold broken by a short glitch tells a restarting count from an accumulating one. Mask, enable and write-0 accesses show which state gates the interrupt and which clears it, and a timed window around the expected set cycle shows that the prescaler restarts from idle.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int DEB_W = 12;

    typedef struct packed {
        logic [DEB_W-1:0] deb;
        logic             lvl;
        logic             en;
    } chan_cfg_t;
endpackage

// File: rtl/eic_tick_gen.sv
module eic_tick_gen #(
    parameter int DIV = 1000,
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic          tick,
    output logic [PW-1:0] cnt_o
);
    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == PW'(DIV - 1));
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/eic_deb_chan.sv
module eic_deb_chan
    import eic_pkg::*;
#(
    parameter int DBW = DEB_W,
    localparam int CW = DBW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           din,
    input  logic           tick,
    input  logic           en,
    input  logic           lvl,
    input  logic [DBW-1:0] deb,
    output logic           busy,
    output logic           event_o
);
    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          armed;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        at_lvl;

    always_comb begin
        st_d    = st_q;
        event_o = 1'b0;
        st_d.sync = {st_q.sync[0], din};
        at_lvl  = (st_q.sync[1] == lvl);
        if (!en || !at_lvl) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else if (st_q.armed && tick) begin
            if (st_q.cnt == ({1'b0, deb} + CW'(1))) begin
                event_o    = 1'b1;
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
        busy = en && at_lvl && st_q.armed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sync: 2'b00, cnt: '0, armed: 1'b1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ext_irq_debounce.sv
module ext_irq_debounce
    import eic_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DIV = 1000,
    parameter int DW  = DEB_W + 2,
    localparam int AW = $clog2(NCH + 2),
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NCH-1:0] ext_in,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_out
);
    localparam logic [AW-1:0] MASK_A = AW'(NCH);
    localparam logic [AW-1:0] STAT_A = AW'(NCH + 1);

    typedef struct packed {
        chan_cfg_t [NCH-1:0] cfg;
        logic [NCH-1:0]      mask;
        logic [NCH-1:0]      stat;
    } top_state_t;

    top_state_t     rg_d, rg_q;
    logic [NCH-1:0] busy, ev, en_vec, clr_mask;
    logic           run, tick;
    logic [PW-1:0]  pre_cnt;

    eic_tick_gen #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cnt_o(pre_cnt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        eic_deb_chan #(.DBW(DEB_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .din(ext_in[g]), .tick(tick),
            .en(rg_q.cfg[g].en), .lvl(rg_q.cfg[g].lvl), .deb(rg_q.cfg[g].deb),
            .busy(busy[g]), .event_o(ev[g])
        );
        assign en_vec[g] = rg_q.cfg[g].en;
    end

    assign run = |busy;

    always_comb begin
        rg_d     = rg_q;
        clr_mask = '0;
        if (reg_we) begin
            for (int i = 0; i < NCH; i++)
                if (reg_addr == AW'(i)) rg_d.cfg[i] = reg_wdata[DEB_W+1:0];
            if (reg_addr == MASK_A) rg_d.mask = reg_wdata[NCH-1:0];
            if (reg_addr == STAT_A) clr_mask = reg_wdata[NCH-1:0];
        end
        rg_d.stat = (rg_q.stat & ~clr_mask) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (reg_addr == AW'(i)) reg_rdata = DW'(rg_q.cfg[i]);
        if (reg_addr == MASK_A) reg_rdata = DW'(rg_q.mask);
        if (reg_addr == STAT_A) reg_rdata = DW'(rg_q.stat);
    end

    assign irq_out = |(rg_q.stat & en_vec & rg_q.mask);
endmodule

// File: rtl/eic_irq_checker.sv
module eic_irq_checker #(
    parameter int NCH = 8,
    parameter int PW  = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           irq_out,
    input logic [NCH-1:0] status,
    input logic [NCH-1:0] en,
    input logic [NCH-1:0] clr,
    input logic           tick,
    input logic           run,
    input logic [PW-1:0]  pre_cnt
);
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_cnt == '0));

    p_set_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status)) != '0) |-> $past(tick));

    p_set_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(en)) == '0));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(status & ~clr)) == $past(status & ~clr)));

    p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (status != '0));
endmodule

bind ext_irq_debounce eic_irq_checker #(.NCH(NCH), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .status(rg_q.stat),
    .en(en_vec), .clr(clr_mask), .tick(tick), .run(run), .pre_cnt(pre_cnt)
);

// File: tb/ext_irq_debounce_test.sv
module ext_irq_debounce_test;
    localparam int NCH = 8;
    localparam int DIV = 20;
    localparam int DW  = 14;
    localparam int AW  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] ext_in = '0;
    logic           reg_we = 1'b0;
    logic [AW-1:0]  reg_addr = '0;
    logic [DW-1:0]  reg_wdata = '0;
    logic [DW-1:0]  reg_rdata;
    logic           irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ext_irq_debounce #(.NCH(NCH), .DIV(DIV), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    // ch[32:30] lvl[29] deb[28:17] hold[16:1] expect[0]
    localparam logic [32:0] VEC [8] = '{
        {3'd0, 1'b1, 12'd0, 16'd10,  1'b0},
        {3'd1, 1'b1, 12'd0, 16'd60,  1'b1},
        {3'd2, 1'b0, 12'd1, 16'd80,  1'b1},
        {3'd3, 1'b1, 12'd2, 16'd70,  1'b0},
        {3'd4, 1'b1, 12'd2, 16'd100, 1'b1},
        {3'd7, 1'b0, 12'd0, 16'd15,  1'b0},
        {3'd5, 1'b1, 12'd4, 16'd140, 1'b1},
        {3'd6, 1'b0, 12'd3, 16'd90,  1'b0}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = AW'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ctl(input bit en, input bit lvl, input int d);
        return (d << 2) | (int'(lvl) << 1) | int'(en);
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R1 reset state
        rd(0, v); chk(v, 0, "R1 ctrl0");
        rd(NCH, v); chk(v, 0, "R1 mask");
        rd(NCH + 1, v); chk(v, 0, "R1 status");
        chk(int'(irq_out), 0, "R1 irq");

        // R2 readback
        wr(3, ctl(1, 0, 1234));
        rd(3, v); chk(v, ctl(1, 0, 1234), "R2 ctrl3 readback");
        wr(3, 0);
        wr(NCH, 8'hA5);
        rd(NCH, v); chk(v, 8'hA5, "R2 mask readback");
        wr(NCH, 8'hFF);

        // R3/R4/R10 table walk
        for (int k = 0; k < 8; k++) begin
            int ch, d, hold;
            bit lvl, ex;
            ch = int'(VEC[k][32:30]); lvl = VEC[k][29];
            d = int'(VEC[k][28:17]); hold = int'(VEC[k][16:1]); ex = VEC[k][0];
            ext_in[ch] = ~lvl;
            cyc(4);
            wr(ch, ctl(1, lvl, d));
            cyc(4);
            ext_in[ch] = lvl;
            cyc(hold);
            ext_in[ch] = ~lvl;
            cyc(3 * DIV);
            rd(NCH + 1, v);
            chk((v >> ch) & 1, int'(ex), $sformatf("R3 R4 R10 vector %0d", k));
            wr(ch, 0);
            wr(NCH + 1, 8'hFF);
        end

        // R3/R9 timing window from idle, D=2
        ext_in = '0;
        wr(0, ctl(1, 1, 2));
        cyc(50);
        ext_in[0] = 1'b1;
        cyc(4 * DIV - DIV / 2);
        rd(NCH + 1, v); chk(v & 1, 0, "R3 R9 before window");
        cyc(DIV);
        rd(NCH + 1, v); chk(v & 1, 1, "R3 R9 after window");
        chk(int'(irq_out), 1, "R8 irq set");

        // R8 mask and enable gating
        wr(NCH, 8'hFE);
        chk(int'(irq_out), 0, "R8 masked");
        wr(NCH, 8'hFF);
        chk(int'(irq_out), 1, "R8 unmasked");

        // R7 write 0 leaves, write 1 clears
        wr(NCH + 1, 8'h00);
        rd(NCH + 1, v); chk(v & 1, 1, "R7 write0 keeps");
        wr(NCH + 1, 8'h01);
        rd(NCH + 1, v); chk(v & 1, 0, "R7 write1 clears");
        chk(int'(irq_out), 0, "R8 irq after clear");

        // R6 held input does not re-fire after clear
        cyc(10 * DIV);
        rd(NCH + 1, v); chk(v & 1, 0, "R6 no refire while held");
        ext_in[0] = 1'b0;
        cyc(10);
        ext_in[0] = 1'b1;
        cyc(6 * DIV);
        rd(NCH + 1, v); chk(v & 1, 1, "R6 refire after release");
        wr(0, ctl(0, 1, 2));
        rd(NCH + 1, v); chk(v & 1, 1, "R8 status kept when disabled");
        chk(int'(irq_out), 0, "R8 irq off when disabled");
        wr(NCH + 1, 8'hFF);
        ext_in[0] = 1'b0;

        // R5 restart on glitch, D=3 needs ~5 ticks
        wr(1, ctl(1, 1, 3));
        cyc(4);
        ext_in[1] = 1'b1; cyc(70);
        ext_in[1] = 1'b0; cyc(3);
        ext_in[1] = 1'b1; cyc(70);
        ext_in[1] = 1'b0;
        cyc(3 * DIV);
        rd(NCH + 1, v); chk((v >> 1) & 1, 0, "R5 restart on glitch");
        wr(1, 0);

        // R11 disabled channel ignores input
        wr(2, ctl(0, 1, 0));
        ext_in[2] = 1'b1;
        cyc(10 * DIV);
        rd(NCH + 1, v); chk((v >> 2) & 1, 0, "R11 disabled no event");
        ext_in[2] = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule